// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This unit gathers eight single-bit event lines from a serial bus controller and its data queues into a latched status word. Each line sets its status bit on a low-to-high transition. The bit stays set until software toggles it off. A per-source enable mask and a global gate together decide whether the single level-sensitive interrupt line is driven. Software reaches the unit through a plain register strobe: a write valid, a byte offset and a 32-bit data word. Read data is returned combinationally for the offset that is presented.

Software acknowledges an event by writing back only the status bits it read as set. A write of one flips a bit and a write of zero leaves it alone, so a bit that was never set must not be written. A keyed write to the reset register clears every status, enable and gate bit in the unit. The same write raises a one-cycle reset pulse for the rest of the peripheral.

Top module: `irq_ctrl`

## Requirements
- R1: After reset every readable register returns zero, `irq_o` is low and `soft_rst_o` is low.
- R2: A 0-to-1 transition on `ev_i[n]` sets status bit n one clock later. A level held high does not set the bit again after software clears it. A fresh rising edge sets it again.
- R3: A write to the status register at offset 0x020 flips every status bit whose data bit is 1 and leaves every bit whose data bit is 0 unchanged. This includes setting a bit that was clear.
- R4: Writing the per-source enable register at offset 0x028 stores bits 7:0. `irq_o` is high exactly when the global gate is set and at least one status bit has its enable bit set.
- R5: The global gate is bit 31 of the register at offset 0x01C. With that bit at 0, `irq_o` stays low whatever the status and enable bits hold.
- R6: A write of exactly 0x0000000A to offset 0x040 clears status, enables and the global gate at that clock edge. It drives `soft_rst_o` high for exactly the following cycle.
- R7: A write of any other value to offset 0x040 changes no register and leaves `soft_rst_o` low.
- R8: Bits 31:8 of the status and enable registers read as zero. Bits 30:0 of the gate register read as zero. The reset register and unmapped offsets read as zero.
- R9: Source bit n is event line n. The lines are: 0 arbitration lost, 1 transmit not acknowledged, 2 transmit queue empty, 3 receive queue at its programmed depth, 4 bus idle, 5 selected as target, 6 no longer selected, 7 transmit queue half empty.
- R10: When a rising edge and a status toggle write hit the same bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_i | input | 8 | Event lines, one per source |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Level interrupt request |
| soft_rst_o | output | 1 | One-cycle reset pulse to the peripheral |

## Verification
On every cycle the assertions check five things. The gate masks the interrupt line. Status holds when neither an edge nor a write touches it. A toggle write yields the previous status XOR the data. The reset pulse lasts one cycle and coincides with cleared registers. Unused read bits stay zero.

Some behaviour only the directed scenarios can show. These are the mapping of each event line to its bit and the refusal to re-set a bit under a held level. They also cover the rule for an edge that collides with a toggle write, and the effect of near-miss reset keys.

// File: rtl/irq_pkg.sv
package irq_pkg;
  // Byte offsets of the register window
  localparam int unsigned OFS_GATE   = 32'h01C;
  localparam int unsigned OFS_STATUS = 32'h020;
  localparam int unsigned OFS_ENABLE = 32'h028;
  localparam int unsigned OFS_RESET  = 32'h040;
  localparam int unsigned RESET_KEY  = 32'h0000_000A;

  // Source order (bit positions are behaviour: software decodes them)
  typedef enum int unsigned {
    SRC_ARB_LOST  = 0,
    SRC_TX_NACK   = 1,
    SRC_TXQ_EMPTY = 2,
    SRC_RXQ_DEPTH = 3,
    SRC_BUS_IDLE  = 4,
    SRC_SELECTED  = 5,
    SRC_DESELECT  = 6,
    SRC_TXQ_HALF  = 7
  } irq_src_e;

  // Next status: toggle on write, set on edge (edge wins), clear on key
  function automatic logic [7:0] status_next(input logic [7:0] cur,
                                             input logic [7:0] tog,
                                             input logic [7:0] rise,
                                             input logic       clr);
    logic [7:0] nxt;
    nxt = (cur ^ tog) | rise;
    if (clr) nxt = '0;
    return nxt;
  endfunction
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] ev_i,
  output logic [N_SRC-1:0] rise_o
);
  logic [N_SRC-1:0] ev_q;

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ev_q[i] <= 1'b0;
      else        ev_q[i] <= ev_i[i];
    end
    assign rise_o[i] = ev_i[i] & ~ev_q[i];
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] rise_i,
  input  logic [N_SRC-1:0] tog_i,
  input  logic             clr_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] nxt;

  always_comb begin
    nxt = (status_o ^ tog_i) | rise_i;
    if (clr_i) nxt = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_o <= '0;
    else        status_o <= nxt;
  end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              gate_o,
  output logic [N_SRC-1:0]  enable_o,
  output logic [N_SRC-1:0]  tog_o,
  output logic              key_hit_o,
  output logic              srst_o
);
  import irq_pkg::*;

  logic wr_gate, wr_en_reg, wr_stat, wr_rst;

  assign wr_gate   = wr_en && (reg_addr == ADDR_W'(OFS_GATE));
  assign wr_en_reg = wr_en && (reg_addr == ADDR_W'(OFS_ENABLE));
  assign wr_stat   = wr_en && (reg_addr == ADDR_W'(OFS_STATUS));
  assign wr_rst    = wr_en && (reg_addr == ADDR_W'(OFS_RESET));
  assign key_hit_o = wr_rst && (wr_data == DATA_W'(RESET_KEY));
  assign tog_o     = wr_stat ? wr_data[N_SRC-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_o   <= 1'b0;
      enable_o <= '0;
      srst_o   <= 1'b0;
    end else begin
      srst_o <= key_hit_o;
      if (key_hit_o) begin
        gate_o   <= 1'b0;
        enable_o <= '0;
      end else begin
        if (wr_gate)   gate_o   <= wr_data[DATA_W-1];
        if (wr_en_reg) enable_o <= wr_data[N_SRC-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  ev_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o,
  output logic              soft_rst_o
);
  import irq_pkg::*;

  localparam int unsigned PAD_W = DATA_W - N_SRC;

  // Named internal events for the checker
  logic [N_SRC-1:0] rise;
  logic [N_SRC-1:0] tog;
  logic [N_SRC-1:0] status_q;
  logic [N_SRC-1:0] enable_q;
  logic             gate_q;
  logic             key_hit;
  logic             pending;

  irq_edge_detect #(.N_SRC(N_SRC)) u_edge (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .rise_o(rise)
  );

  irq_cfg_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .gate_o(gate_q), .enable_o(enable_q), .tog_o(tog),
    .key_hit_o(key_hit), .srst_o(soft_rst_o)
  );

  irq_status_reg #(.N_SRC(N_SRC)) u_stat (
    .clk(clk), .rst_n(rst_n), .rise_i(rise), .tog_i(tog),
    .clr_i(key_hit), .status_o(status_q)
  );

  assign pending = |(status_q & enable_q);
  assign irq_o   = gate_q & pending;

  always_comb begin
    rd_data = '0;
    if (reg_addr == ADDR_W'(OFS_GATE))
      rd_data = {gate_q, {(DATA_W-1){1'b0}}};
    else if (reg_addr == ADDR_W'(OFS_STATUS))
      rd_data = {{PAD_W{1'b0}}, status_q};
    else if (reg_addr == ADDR_W'(OFS_ENABLE))
      rd_data = {{PAD_W{1'b0}}, enable_q};
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned N_SRC  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq_o,
  input logic              soft_rst_o,
  input logic [N_SRC-1:0]  status_q,
  input logic [N_SRC-1:0]  enable_q,
  input logic              gate_q,
  input logic [N_SRC-1:0]  rise,
  input logic              key_hit
);
  import irq_pkg::*;

  logic stat_wr, quiet;
  assign stat_wr = wr_en && (reg_addr == ADDR_W'(OFS_STATUS));
  assign quiet   = (rise == '0) && !key_hit;

  // R5
  gate_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_q |-> !irq_o);

  // R2
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && !stat_wr) |=> $stable(status_q));

  // R3
  toggle_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && stat_wr) |=> status_q == $past(status_q ^ wr_data[N_SRC-1:0]));

  // R6
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |-> (status_q == '0 && enable_q == '0 && !gate_q));

  // R6
  reset_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst_o && !key_hit) |=> !soft_rst_o);

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_W'(OFS_STATUS) || reg_addr == ADDR_W'(OFS_ENABLE))
      |-> rd_data[DATA_W-1:N_SRC] == '0);
endmodule

bind irq_ctrl irq_ctrl_chk #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
  .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .soft_rst_o(soft_rst_o),
  .status_q(status_q), .enable_q(enable_q), .gate_q(gate_q), .rise(rise),
  .key_hit(key_hit)
);

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ev_i = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq_o, soft_rst_o;
  int          n_chk = 0, n_err = 0;
  bit          finished = 0;

  localparam logic [7:0] A_GATE = 8'h1C, A_STAT = 8'h20, A_EN = 8'h28, A_RST = 8'h40;

  always #4 clk = ~clk;

  irq_ctrl i_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .rd_data(rd_data), .irq_o(irq_o), .soft_rst_o(soft_rst_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = rd_data;
  endtask

  task automatic pulse(int b);
    @(negedge clk); ev_i[b] = 1'b1;
    @(negedge clk); ev_i[b] = 1'b0;
    @(negedge clk);
  endtask

  task automatic clean();
    wr(A_RST, 32'h0000_000A);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(A_GATE, d); chk("R1 gate", d, 0);
    rd(A_STAT, d); chk("R1 status", d, 0);
    rd(A_EN, d);   chk("R1 enable", d, 0);
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 srst", {31'b0, soft_rst_o}, 0);
  endtask

  task automatic t_order();
    logic [31:0] d;
    clean();
    for (int b = 0; b < 8; b++) begin
      pulse(b);
      rd(A_STAT, d); chk("R9 source bit", d, 32'h1 << b);
      wr(A_STAT, 32'h1 << b);
    end
  endtask

  task automatic t_level();
    logic [31:0] d;
    clean();
    @(negedge clk); ev_i[3] = 1'b1;
    @(negedge clk);
    rd(A_STAT, d); chk("R2 edge sets", d, 32'h08);
    wr(A_STAT, 32'h08);
    @(negedge clk);
    rd(A_STAT, d); chk("R2 held level no reset", d, 32'h00);
    ev_i[3] = 1'b0;
    @(negedge clk); ev_i[3] = 1'b1;
    @(negedge clk); ev_i[3] = 1'b0;
    rd(A_STAT, d); chk("R2 fresh edge", d, 32'h08);
  endtask

  task automatic t_toggle();
    logic [31:0] d;
    clean();
    pulse(5);
    wr(A_STAT, 32'h21);
    rd(A_STAT, d); chk("R3 toggle both", d, 32'h01);
    wr(A_STAT, 32'h00);
    rd(A_STAT, d); chk("R3 zero write", d, 32'h01);
    wr(A_STAT, 32'hFFFF_FF00);
    rd(A_STAT, d); chk("R3 upper data ignored", d, 32'h01);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    clean();
    pulse(5);
    wr(A_GATE, 32'h8000_0000);
    chk("R4 no enable", {31'b0, irq_o}, 0);
    wr(A_EN, 32'h20);
    chk("R4 enabled", {31'b0, irq_o}, 1);
    wr(A_EN, 32'h10);
    chk("R4 other enable", {31'b0, irq_o}, 0);
    wr(A_EN, 32'hFFFF_FF30);
    rd(A_EN, d); chk("R8 enable upper", d, 32'h30);
    chk("R4 again", {31'b0, irq_o}, 1);
    wr(A_STAT, 32'h20);
    chk("R4 acked", {31'b0, irq_o}, 0);
  endtask

  task automatic t_gate();
    logic [31:0] d;
    clean();
    pulse(1);
    wr(A_EN, 32'h02);
    chk("R5 gate off", {31'b0, irq_o}, 0);
    wr(A_GATE, 32'hFFFF_FFFF);
    rd(A_GATE, d); chk("R8 gate readback", d, 32'h8000_0000);
    chk("R5 gate on", {31'b0, irq_o}, 1);
    wr(A_GATE, 32'h7FFF_FFFF);
    chk("R5 gate cleared", {31'b0, irq_o}, 0);
  endtask

  task automatic t_softrst();
    logic [31:0] d;
    clean();
    pulse(0); pulse(7);
    wr(A_EN, 32'hFF);
    wr(A_GATE, 32'h8000_0000);
    chk("R6 precondition irq", {31'b0, irq_o}, 1);
    wr(A_RST, 32'h0000_000A);
    chk("R6 pulse high", {31'b0, soft_rst_o}, 1);
    chk("R6 irq low", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R6 pulse one cycle", {31'b0, soft_rst_o}, 0);
    rd(A_STAT, d); chk("R6 status cleared", d, 0);
    rd(A_EN, d);   chk("R6 enable cleared", d, 0);
    rd(A_GATE, d); chk("R6 gate cleared", d, 0);
    rd(A_RST, d);  chk("R8 reset reads zero", d, 0);
    rd(8'h24, d);  chk("R8 unmapped zero", d, 0);
  endtask

  task automatic t_badkey();
    logic [31:0] d;
    clean();
    pulse(4);
    wr(A_EN, 32'h10);
    wr(A_RST, 32'h0000_000B);
    chk("R7 key 0B no pulse", {31'b0, soft_rst_o}, 0);
    wr(A_RST, 32'h0000_010A);
    chk("R7 key 10A no pulse", {31'b0, soft_rst_o}, 0);
    rd(A_STAT, d); chk("R7 status kept", d, 32'h10);
    rd(A_EN, d);   chk("R7 enable kept", d, 32'h10);
  endtask

  task automatic t_collide();
    logic [31:0] d;
    clean();
    pulse(2);
    @(negedge clk);
    ev_i[2] = 1'b1; wr_en = 1'b1; reg_addr = A_STAT; wr_data = 32'h04;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; ev_i[2] = 1'b0;
    rd(A_STAT, d); chk("R10 edge wins", d, 32'h04);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_order();
    t_level();
    t_toggle();
    t_enable();
    t_gate();
    t_softrst();
    t_badkey();
    t_collide();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule